// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block sits between a set of peripheral request lines and a CPU. It routes 22 request sources onto 10 vector slots. A slot's request is the OR of the sources routed to it. Each slot has an enable bit, and a one-bit level choice selects its priority. Every clock the controller chooses, among the enabled and requesting slots, the one with the highest priority. It presents that slot's vector address to the CPU together with a valid flag.

Nesting works on three priority levels, and a new request is offered only when its level is strictly above the level now in service. When the CPU acknowledges, the controller saves the interrupted level on a small stack and raises the service level to the winner's level. When the CPU returns from the handler, the controller restores the saved level. Clearing the request flags is left to the peripherals.

Top module: `prio_intc`

## Requirements
- R1: After reset, `vecValid` is 0, `vecAddr` is 0 and `curLevel` is 0. `vecAddr` reads 0 whenever `vecValid` is 0.
- R2: The vector address of slot k (k = 0..9) is 3 + 8*k, which gives 03h, 0Bh, and so on up to 4Bh.
- R3: `curLevel` encodes 0 = no interrupt in service, 1 = low, 2 = high and 3 = highest. When `slotHigh[k]` is 0, slot k runs at low. When it is 1, slots 0 and 1 run at highest and slots 2..9 run at high.
- R4: Source s (s = 0..21) feeds slot s when s < 10, and slot 2 + ((s - 10) mod 8) otherwise. Sources that share a slot are ORed together.
- R5: A slot whose `slotEn` bit is 0 never wins, whatever its requests.
- R6: Among the slots that are eligible, the slot with the highest level wins. Between slots of equal level, the lower slot number, which is also the lower address, wins.
- R7: A slot is eligible only if its level is strictly greater than `curLevel`. Requests at or below the level in service are held off.
- R8: `vecValid` and `vecAddr` are registered. They reflect the inputs sampled at the previous rising clock edge.
- R9: An acknowledge (`intAck` high while `vecValid` is high) sets `curLevel` to the winner's level at that edge. The same edge forces `vecValid` low for one cycle, and arbitration then resumes against the new level.
- R10: A return (`intRet` high while `curLevel` is nonzero) restores the level that was interrupted. Returning from the outermost handler gives `curLevel` 0. Nesting is at most three deep.
- R11: An acknowledge while `vecValid` is 0 leaves `curLevel` unchanged. A return while `curLevel` is 0 leaves `curLevel` unchanged. When `intAck` and `intRet` are high together, only the return takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| srcReq | input | 22 | Request lines from the sources |
| slotEn | input | 10 | Per-slot enable |
| slotHigh | input | 10 | Per-slot level choice (0 = low, 1 = upper level) |
| intAck | input | 1 | CPU takes the presented vector |
| intRet | input | 1 | CPU leaves the current handler |
| vecValid | output | 1 | A vector is offered |
| vecAddr | output | 8 | Address of the offered vector |
| curLevel | output | 2 | Level now in service |

## Verification
The bench sweeps several hundred pseudo-random mixes of requests, enables and level choices and compares each against an arithmetic winner model. This catches a tie broken toward the higher slot, or a shared source routed to the wrong slot. Directed sequences nest low, then high, then highest and unwind again. A design that lets an equal-level request preempt would show `vecValid` where none is expected. A design that pops the wrong stack entry would return to the wrong level. The bench also acknowledges twice in a row. A controller that did not squash its stale registered vector would take the same slot twice. The bench then checks acknowledges with nothing offered, a return at base, and an acknowledge and return in the same cycle, to show that none of these changes the level wrongly.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
package prio_intc_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } level_t;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic push;
    logic pop;
    logic squash;
  } ctrl_strobe_t;

  // Routing of a source onto its slot: the first numSlots sources map one to
  // one; the rest wrap over the slots that only take high or low.
  function automatic int srcSlot(input int src, input int numSlots, input int topSlots);
    if (src < numSlots) return src;
    return topSlots + ((src - numSlots) % (numSlots - topSlots));
  endfunction

endpackage

// File: rtl/prio_intc_arb.sv
`timescale 1ns/1ps
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int NUM_SRC   = 22,
  parameter int TOP_SLOTS = 2,
  parameter int ADDR_W    = 8,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcReq,
  input  logic [NUM_SLOTS-1:0] slotEn,
  input  logic [NUM_SLOTS-1:0] slotHigh,
  input  level_t               curLevel,
  input  ctrl_strobe_t         strobe,
  output logic                 vecValid,
  output logic [ADDR_W-1:0]    vecAddr,
  output level_t               vecLevel
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] slotReq;
  level_t               slotLvl [NUM_SLOTS];
  level_t               bestLvl;
  logic [IDX_W-1:0]     bestIdx;
  logic                 hit;
  logic                 unusedStrobes;

  assign unusedStrobes = ^{strobe.push, strobe.pop};

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : gSlot
      always_comb begin
        slotReq[g] = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
          if (srcSlot(s, NUM_SLOTS, TOP_SLOTS) == g) slotReq[g] = slotReq[g] | srcReq[s];
        end
      end
      if (g < TOP_SLOTS) begin : gTop
        assign slotLvl[g] = slotHigh[g] ? LVL_TOP : LVL_LOW;
      end else begin : gMid
        assign slotLvl[g] = slotHigh[g] ? LVL_HIGH : LVL_LOW;
      end
    end
  endgenerate

  // Scan from the top slot down so that a lower slot of equal level overrides.
  always_comb begin
    bestLvl = LVL_NONE;
    bestIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slotReq[i] && slotEn[i] && (slotLvl[i] > curLevel) && (slotLvl[i] >= bestLvl)) begin
        bestLvl = slotLvl[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  assign hit = (bestLvl != LVL_NONE);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.squash) begin
      vecValid <= 1'b0;
      vecAddr  <= '0;
      vecLevel <= LVL_NONE;
    end else begin
      vecValid <= hit;
      vecAddr  <= hit ? ADDR_W'(VEC_BASE + VEC_STEP * int'(bestIdx)) : '0;
      vecLevel <= bestLvl;
    end
  end

endmodule

// File: rtl/prio_intc_ctrl.sv
`timescale 1ns/1ps
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter int STACK_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         intAck,
  input  logic         intRet,
  input  logic         vecValid,
  input  level_t       vecLevel,
  output level_t       curLevel,
  output ctrl_strobe_t strobe
);

  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);
  localparam int SIDX_W  = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  level_t             stackMem [STACK_DEPTH];
  logic [DEPTH_W-1:0] depth;
  logic               ackOk;
  logic               retOk;

  assign retOk = intRet && (curLevel != LVL_NONE);
  assign ackOk = intAck && vecValid && !intRet;

  always_comb begin
    strobe.push   = ackOk && (curLevel != LVL_NONE) && (depth < DEPTH_W'(STACK_DEPTH));
    strobe.pop    = retOk && (depth != '0);
    strobe.squash = ackOk || retOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel <= LVL_NONE;
      depth    <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stackMem[i] <= LVL_NONE;
    end else if (retOk) begin
      if (strobe.pop) begin
        curLevel <= stackMem[SIDX_W'(depth - 1'b1)];
        depth    <= depth - 1'b1;
      end else begin
        curLevel <= LVL_NONE;
      end
    end else if (ackOk) begin
      if (strobe.push) begin
        stackMem[SIDX_W'(depth)] <= curLevel;
        depth                    <= depth + 1'b1;
      end
      curLevel <= vecLevel;
    end
  end

endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SLOTS   = 10,
  parameter int NUM_SRC     = 22,
  parameter int TOP_SLOTS   = 2,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  parameter int STACK_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcReq,
  input  logic [NUM_SLOTS-1:0] slotEn,
  input  logic [NUM_SLOTS-1:0] slotHigh,
  input  logic                 intAck,
  input  logic                 intRet,
  output logic                 vecValid,
  output logic [ADDR_W-1:0]    vecAddr,
  output logic [1:0]           curLevel
);

  level_t       curLvl;
  level_t       vecLvl;
  ctrl_strobe_t strobe;

  prio_intc_arb #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .TOP_SLOTS(TOP_SLOTS),
    .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .slotEn(slotEn), .slotHigh(slotHigh),
    .curLevel(curLvl), .strobe(strobe),
    .vecValid(vecValid), .vecAddr(vecAddr), .vecLevel(vecLvl)
  );

  prio_intc_ctrl #(
    .STACK_DEPTH(STACK_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .intRet(intRet),
    .vecValid(vecValid), .vecLevel(vecLvl),
    .curLevel(curLvl), .strobe(strobe)
  );

  assign curLevel = curLvl;

endmodule

// File: rtl/prio_intc_chk.sv
`timescale 1ns/1ps
module prio_intc_chk #(
  parameter int NUM_SLOTS = 10,
  parameter int NUM_SRC   = 22,
  parameter int ADDR_W    = 8,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               intAck,
  input logic               intRet,
  input logic               vecValid,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [1:0]         curLevel
);

  localparam int LAST_ADDR = VEC_BASE + VEC_STEP * (NUM_SLOTS - 1);

  p_addr_grid_r2: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (int'(vecAddr) <= LAST_ADDR && ((int'(vecAddr) - VEC_BASE) % VEC_STEP) == 0));

  p_idle_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> vecAddr == '0);

  p_top_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> curLevel != 2'd3);

  p_no_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq == '0) |=> !vecValid);

  p_ack_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && vecValid && !intRet) |=> (curLevel > $past(curLevel) && !vecValid));

  p_ret_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intRet && curLevel != 2'd0) |=> curLevel < $past(curLevel));

  p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !vecValid && !intRet) |=> $stable(curLevel));

  p_ret_base_r11: assert property (@(posedge clk) disable iff (!rstN)
    (intRet && curLevel == 2'd0) |=> curLevel == 2'd0);

endmodule

bind prio_intc prio_intc_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .intAck(intAck), .intRet(intRet),
  .vecValid(vecValid), .vecAddr(vecAddr), .curLevel(curLevel)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] srcReq = '0;
  logic [9:0]  slotEn = '0;
  logic [9:0]  slotHigh = '0;
  logic        intAck = 1'b0;
  logic        intRet = 1'b0;
  logic        vecValid;
  logic [7:0]  vecAddr;
  logic [1:0]  curLevel;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .slotEn(slotEn), .slotHigh(slotHigh),
    .intAck(intAck), .intRet(intRet),
    .vecValid(vecValid), .vecAddr(vecAddr), .curLevel(curLevel)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int mapSlot(input int s);
    return (s < 10) ? s : 2 + ((s - 10) % 8);
  endfunction

  function automatic int slotLevel(input int k, input bit hi);
    if (!hi) return 1;
    return (k < 2) ? 3 : 2;
  endfunction

  // Arithmetic winner: highest level above cur, lowest slot on ties.
  task automatic model(input logic [21:0] req, input logic [9:0] en, input logic [9:0] hi,
                       input int cur, output int v, output int addr);
    int bestL = 0;
    int bestI = 0;
    for (int k = 0; k < 10; k++) begin
      bit r = 0;
      for (int s = 0; s < 22; s++) if (mapSlot(s) == k && req[s]) r = 1;
      if (r && en[k] && slotLevel(k, hi[k]) > cur && slotLevel(k, hi[k]) > bestL) begin
        bestL = slotLevel(k, hi[k]);
        bestI = k;
      end
    end
    v    = (bestL != 0) ? 1 : 0;
    addr = v ? 3 + 8 * bestI : 0;
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic pulseAck();
    intAck = 1'b1; step(1); intAck = 1'b0;
  endtask

  task automatic pulseRet();
    intRet = 1'b1; step(1); intRet = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, a;
    step(3);
    // R1: reset state
    check("R1 valid", vecValid, 0);
    check("R1 addr", vecAddr, 0);
    check("R1 level", curLevel, 0);
    rstN = 1'b1;
    step(2);
    check("R1 idle valid", vecValid, 0);

    // R2, R3: every slot alone at both level choices
    slotEn = '1;
    for (int k = 0; k < 10; k++) begin
      for (int hi = 0; hi < 2; hi++) begin
        slotHigh = '0;
        slotHigh[k] = hi[0];
        srcReq = '0;
        srcReq[k] = 1'b1;
        step(1);
        check("R2 valid", vecValid, 1);
        check("R2 addr", vecAddr, 3 + 8 * k);
        pulseAck();
        check("R3 level", curLevel, slotLevel(k, hi[0]));
        check("R9 squash", vecValid, 0);
        srcReq = '0;
        pulseRet();
        check("R10 back to base", curLevel, 0);
      end
    end

    // R8: output changes only after the edge
    slotHigh = '0;
    srcReq = '0;
    step(2);
    srcReq[7] = 1'b1;
    #1;
    check("R8 before edge", vecValid, 0);
    step(1);
    check("R8 after edge", vecAddr, 3 + 8 * 7);

    // R4: each source alone reaches its slot
    for (int s = 0; s < 22; s++) begin
      srcReq = '0;
      srcReq[s] = 1'b1;
      step(1);
      check("R4 routing", vecAddr, 3 + 8 * mapSlot(s));
    end

    // R5: disabled slot never wins
    for (int k = 0; k < 10; k++) begin
      slotEn = '1;
      slotEn[k] = 1'b0;
      srcReq = '0;
      srcReq[k] = 1'b1;
      step(1);
      check("R5 gated", vecValid, 0);
    end

    // R6: pseudo-random sweep at base level
    for (int n = 0; n < 400; n++) begin
      seed = nextRand(seed); srcReq = seed[21:0];
      if (n % 4 == 0) srcReq = srcReq & 22'h000421;
      seed = nextRand(seed); slotHigh = seed[9:0];
      seed = nextRand(seed); slotEn = seed[9:0] | seed[19:10];
      step(1);
      model(srcReq, slotEn, slotHigh, 0, v, a);
      check("R6 sweep valid", vecValid, v);
      check("R6 sweep addr", vecAddr, a);
    end

    // R7, R9, R10: nest low -> high -> highest and unwind
    srcReq = '0; slotEn = '1; slotHigh = '0;
    slotHigh[0] = 1'b1; slotHigh[3] = 1'b1;
    step(2);
    srcReq[5] = 1'b1;
    step(1);
    check("R9 low offered", vecAddr, 3 + 8 * 5);
    pulseAck();
    check("R9 level low", curLevel, 1);
    check("R9 squash", vecValid, 0);
    srcReq[6] = 1'b1;
    step(2);
    check("R7 equal blocked", vecValid, 0);
    srcReq[3] = 1'b1;
    step(1);
    check("R7 high offered", vecAddr, 3 + 8 * 3);
    pulseAck();
    check("R9 level high", curLevel, 2);
    step(1);
    check("R7 high equal blocked", vecValid, 0);
    srcReq[0] = 1'b1;
    step(1);
    check("R7 top offered", vecAddr, 3);
    pulseAck();
    check("R9 level top", curLevel, 3);
    srcReq = '1;
    step(2);
    check("R7 nothing above top", vecValid, 0);
    srcReq = '0;
    pulseRet();
    check("R10 restore high", curLevel, 2);
    pulseRet();
    check("R10 restore low", curLevel, 1);
    pulseRet();
    check("R10 restore base", curLevel, 0);

    // R11: ack with nothing offered, return at base
    step(2);
    pulseAck();
    check("R11 ack ignored", curLevel, 0);
    pulseRet();
    check("R11 ret at base", curLevel, 0);

    // R11: ack and return together -> return only
    srcReq[5] = 1'b1;
    step(1);
    pulseAck();
    check("R11 setup low", curLevel, 1);
    srcReq[0] = 1'b1;
    step(1);
    check("R11 top pending", vecAddr, 3);
    intAck = 1'b1; intRet = 1'b1;
    step(1);
    intAck = 1'b0; intRet = 1'b0;
    check("R11 ret wins", curLevel, 0);
    step(1);
    check("R11 rearbitrated", vecAddr, 3);

    // R9: double ack must not take a stale vector
    srcReq = '0; srcReq[5] = 1'b1;
    step(1);
    intAck = 1'b1;
    step(2);
    intAck = 1'b0;
    check("R9 double ack", curLevel, 1);
    srcReq = '0;
    pulseRet();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule